// File: doc/BRIEF.md
# Host Command-Mode Receiver

This block is the slave end of a two-wire command channel. A host controller owns a serial clock line and shares a data line with the block. The host asks for attention by raising its clock. The block answers by driving data high. When the host drops the clock, the block drives a short low pulse and then releases the line. The host then shifts in a command byte followed by argument bytes, least significant bit first. The host changes data while its clock is low, and the block samples it on each falling edge. Both lines reach the block asynchronously and are resynchronised to the system clock. Every timing limit is a parameter counted in system clock cycles.

Five opcodes are decoded. Read and write reach a 128-byte user memory through a request/acknowledge port, and both continue sequentially with a 7-bit wrapping address. Learn, erase-all and program produce single-cycle strobes. Erase-all carries a keep-first-slot flag and program carries a configuration byte and a 64-bit code. An opcode outside the set sends the block back to idle. A host that stalls beyond the configured timeouts also sends it back to idle.

Top module: `hcm_cmd_rx`

## Requirements
- R1: Out of reset the data line is released (`hdat_oe` = 0), no memory request is raised and no strobe is asserted.
- R2: From idle, a rising host clock makes the block drive data high while the clock stays high. After the clock falls, the block drives data low for about `ACK_LO_CYC` cycles and then releases it.
- R3: If the host clock stays high for longer than `REQ_MAX_CYC` cycles during a request, the request is dropped. Data is released and no low acknowledge follows the clock's fall.
- R4: Bits are sampled on host clock falling edges, least significant bit first, and the data line is never driven while bits are being shifted in.
- R5: The opcodes are F0h (read), E1h (write), D2h (learn), C3h (erase-all) and B4h (program). Any other command byte returns the block to idle without driving data, so the next rising clock is treated as a fresh request.
- R6: Write (E1h) takes an address byte, of which only bits 6:0 are used, and then a data byte. The next rising host clock commits it as a memory write, and data is held high from the memory acknowledge until the clock falls. Further data bytes write to the next address, modulo 128.
- R7: Read (F0h) takes an address byte and a dummy byte, fetches that location, and presents bit k of the byte on the k-th following rising clock edge. A byte started within `SEQ_WIN_CYC` cycles reads the next address, modulo 128.
- R8: During a transfer, a gap of more than `IDLE_TMO_CYC` cycles without a host clock edge returns the block to idle. So does a wait of more than `SEQ_WIN_CYC` cycles before the first bit of a read byte. No memory write happens after either.
- R9: Learn (D2h) takes two dummy bytes. The next rising clock pulses `learn_stb` and data is held high until the clock falls.
- R10: Erase-all (C3h) takes a subcommand byte and a dummy byte, and the next rising clock pulses `erase_stb`. `erase_keep_first` is 0 for subcommand 00h and 1 for 01h. Any other subcommand returns the block to idle with no strobe.
- R11: Program (B4h) takes a configuration byte and then eight code bytes, the least significant byte first. The next rising clock pulses `prog_stb` with `prog_cfg` and `prog_code` holding those values.
- R12: Each strobe lasts exactly one cycle, at most one strobe is active at a time, and each accepted command produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hclk_i | input | 1 | Host serial clock, asynchronous |
| hdat_i | input | 1 | Data line value seen from the host, asynchronous |
| hdat_o | output | 1 | Value the block drives onto the data line |
| hdat_oe | output | 1 | Drive enable for the data line |
| mem_req | output | 1 | User memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | ADDR_W | User memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Single-cycle access acknowledge |
| learn_stb | output | 1 | Learn command strobe |
| erase_stb | output | 1 | Erase-all command strobe |
| erase_keep_first | output | 1 | Keep-first-slot flag for the last erase |
| prog_stb | output | 1 | Program command strobe |
| prog_cfg | output | 8 | Configuration byte from the last program command |
| prog_code | output | CODE_BYTES*8 | Code from the last program command |

## Verification
The bench builds the block with `ACK_LO_CYC` = 4, `REQ_MAX_CYC` = 300, `IDLE_TMO_CYC` = 150 and `SEQ_WIN_CYC` = 100, and uses a host bit period of 24 system cycles. With these values, the stuck-request, inter-bit-timeout and sequential-read-window expiries each occur within a few hundred cycles. A stall can therefore be placed just past each limit and the block's return to idle observed through the next request handshake. Address and code widths stay at their defaults, so the 7-bit wrap at 127 and the full eight-byte program code are covered directly.

// File: rtl/hcm_pkg.sv
package hcm_pkg;

   localparam logic [7:0] OP_READ  = 8'hF0;
   localparam logic [7:0] OP_WRITE = 8'hE1;
   localparam logic [7:0] OP_LEARN = 8'hD2;
   localparam logic [7:0] OP_ERASE = 8'hC3;
   localparam logic [7:0] OP_PROG  = 8'hB4;

   typedef enum logic [3:0] {
      S_IDLE,
      S_REQ,
      S_ACKLO,
      S_CMD,
      S_ARG,
      S_COMMIT,
      S_RESP,
      S_WMEM,
      S_RMEM,
      S_ROUT,
      S_ABORT
   } rx_state_t;

   function automatic logic op_known(input logic [7:0] b);
      return (b == OP_READ) || (b == OP_WRITE) || (b == OP_LEARN) ||
             (b == OP_ERASE) || (b == OP_PROG);
   endfunction

endpackage

// File: rtl/hcm_line_sync.sv
module hcm_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hclk_i,
   input  logic hdat_i,
   output logic hc_lvl,
   output logic hd_lvl,
   output logic hc_rise,
   output logic hc_fall
);
   logic [STAGES-1:0] c_sync;
   logic [STAGES-1:0] d_sync;
   logic              c_prev;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_sync <= '0;
               d_sync <= '0;
            end else begin
               c_sync <= hclk_i;
               d_sync <= hdat_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_sync <= '0;
               d_sync <= '0;
            end else begin
               c_sync <= {c_sync[STAGES-2:0], hclk_i};
               d_sync <= {d_sync[STAGES-2:0], hdat_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_prev <= 1'b0;
      else        c_prev <= c_sync[STAGES-1];
   end

   assign hc_lvl  = c_sync[STAGES-1];
   assign hd_lvl  = d_sync[STAGES-1];
   assign hc_rise = hc_lvl & ~c_prev;
   assign hc_fall = ~hc_lvl & c_prev;
endmodule

// File: rtl/hcm_byte_rx.sv
module hcm_byte_rx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       sample,
   input  logic       bit_i,
   output logic [7:0] byte_o,
   output logic       done
);
   logic [2:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         byte_o <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (clr) begin
            cnt <= '0;
         end else if (sample) begin
            byte_o <= {bit_i, byte_o[7:1]};
            cnt    <= cnt + 3'd1;
            if (cnt == 3'd7) done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/hcm_timer.sv
module hcm_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/hcm_cmd_rx.sv
module hcm_cmd_rx
   import hcm_pkg::*;
#(
   parameter int ADDR_W       = 7,
   parameter int CODE_BYTES   = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int ACK_LO_CYC   = 100,
   parameter int REQ_MAX_CYC  = 25_000_000,
   parameter int IDLE_TMO_CYC = 60_000,
   parameter int SEQ_WIN_CYC  = 50_000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hclk_i,
   input  logic                    hdat_i,
   output logic                    hdat_o,
   output logic                    hdat_oe,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [7:0]              mem_wdata,
   input  logic [7:0]              mem_rdata,
   input  logic                    mem_ack,
   output logic                    learn_stb,
   output logic                    erase_stb,
   output logic                    erase_keep_first,
   output logic                    prog_stb,
   output logic [7:0]              prog_cfg,
   output logic [CODE_BYTES*8-1:0] prog_code
);
   localparam int CW   = CODE_BYTES * 8;
   localparam int NBW  = $clog2(CODE_BYTES + 2);
   localparam int TM1  = (REQ_MAX_CYC > IDLE_TMO_CYC) ? REQ_MAX_CYC : IDLE_TMO_CYC;
   localparam int TM2  = (SEQ_WIN_CYC > ACK_LO_CYC) ? SEQ_WIN_CYC : ACK_LO_CYC;
   localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
   localparam int TW   = $clog2(TMAX + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
         $error("hcm_cmd_rx: ADDR_W must lie in 1..8");
      end
      if (CODE_BYTES < 2) begin : g_bad_code
         $error("hcm_cmd_rx: CODE_BYTES must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("hcm_cmd_rx: SYNC_STAGES must be at least 1");
      end
      if (ACK_LO_CYC < 1 || IDLE_TMO_CYC < 1 || SEQ_WIN_CYC < 1 || REQ_MAX_CYC < 1) begin : g_bad_tmo
         $error("hcm_cmd_rx: timing limits must be positive");
      end
   endgenerate

   // line conditioning
   logic hc_lvl, hd_lvl, hc_rise, hc_fall;

   hcm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .hclk_i  (hclk_i),
      .hdat_i  (hdat_i),
      .hc_lvl  (hc_lvl),
      .hd_lvl  (hd_lvl),
      .hc_rise (hc_rise),
      .hc_fall (hc_fall)
   );

   rx_state_t st_q, st_d;
   logic      in_rx;

   assign in_rx = (st_q == S_CMD) || (st_q == S_ARG);

   // byte assembly
   logic [7:0] rx_byte;
   logic       bdone;

   hcm_byte_rx u_brx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (~in_rx),
      .sample (in_rx & hc_fall),
      .bit_i  (hd_lvl),
      .byte_o (rx_byte),
      .done   (bdone)
   );

   // timeouts
   logic          tmr_load, tmo;
   logic [TW-1:0] tmr_val;

   hcm_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmo)
   );

   // command context
   logic [7:0]        op_q;
   logic [NBW-1:0]    nbyte_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        wdata_q;
   logic              keep_q;
   logic [7:0]        cfg_q;
   logic [CW-1:0]     code_q;
   logic [7:0]        rd_byte_q;
   logic [2:0]        bit_idx_q;
   logic              drv_q;
   logic              rd_bit_q;

   // argument sequencing
   rx_state_t arg_nx;

   always_comb begin
      arg_nx = S_ARG;
      case (op_q)
         OP_READ:  if (nbyte_q == NBW'(1)) arg_nx = S_RMEM;
         OP_WRITE: if (nbyte_q == NBW'(1)) arg_nx = S_COMMIT;
         OP_LEARN: if (nbyte_q == NBW'(1)) arg_nx = S_COMMIT;
         OP_ERASE: begin
            if (nbyte_q == NBW'(0) && rx_byte > 8'h01) arg_nx = S_ABORT;
            else if (nbyte_q == NBW'(1))               arg_nx = S_COMMIT;
         end
         OP_PROG:  if (nbyte_q == NBW'(CODE_BYTES)) arg_nx = S_COMMIT;
         default:  arg_nx = S_ABORT;
      endcase
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         S_IDLE:   if (hc_rise) st_d = S_REQ;
         S_REQ: begin
            if (!hc_lvl)  st_d = S_ACKLO;
            else if (tmo) st_d = S_ABORT;
         end
         S_ACKLO:  if (tmo) st_d = S_CMD;
         S_CMD: begin
            if (bdone)    st_d = op_known(rx_byte) ? S_ARG : S_ABORT;
            else if (tmo) st_d = S_ABORT;
         end
         S_ARG: begin
            if (bdone)    st_d = arg_nx;
            else if (tmo) st_d = S_ABORT;
         end
         S_COMMIT: begin
            if (hc_rise)  st_d = (op_q == OP_WRITE) ? S_WMEM : S_RESP;
            else if (tmo) st_d = S_ABORT;
         end
         S_WMEM:   if (mem_ack) st_d = hc_lvl ? S_RESP : S_ARG;
         S_RESP:   if (!hc_lvl) st_d = (op_q == OP_WRITE) ? S_ARG : S_IDLE;
         S_RMEM:   if (mem_ack) st_d = S_ROUT;
         S_ROUT: begin
            if (hc_fall && drv_q && bit_idx_q == 3'd7) st_d = S_RMEM;
            else if (tmo)                             st_d = S_ABORT;
         end
         S_ABORT:  if (!hc_lvl) st_d = S_IDLE;
         default:  st_d = S_ABORT;
      endcase
   end

   // timer reload: any state change, or any host edge while a transfer waits on it
   always_comb begin
      tmr_load = (st_d != st_q) ||
                 ((hc_rise || hc_fall) &&
                  (in_rx || st_q == S_COMMIT || st_q == S_ROUT));
      case (st_d)
         S_REQ:   tmr_val = TW'(REQ_MAX_CYC);
         S_ACKLO: tmr_val = TW'(ACK_LO_CYC);
         S_ROUT:  tmr_val = (st_q != S_ROUT) ? TW'(SEQ_WIN_CYC) : TW'(IDLE_TMO_CYC);
         default: tmr_val = TW'(IDLE_TMO_CYC);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= '0;
         nbyte_q   <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
         keep_q    <= 1'b0;
         cfg_q     <= '0;
         code_q    <= '0;
         rd_byte_q <= '0;
         bit_idx_q <= '0;
         drv_q     <= 1'b0;
         rd_bit_q  <= 1'b0;
      end else begin
         if (st_q == S_CMD && bdone) begin
            op_q    <= rx_byte;
            nbyte_q <= '0;
         end
         if (st_q == S_ARG && bdone) begin
            nbyte_q <= nbyte_q + NBW'(1);
            case (op_q)
               OP_READ, OP_WRITE: begin
                  if (nbyte_q == NBW'(0)) addr_q  <= rx_byte[ADDR_W-1:0];
                  else                    wdata_q <= rx_byte;
               end
               OP_ERASE: if (nbyte_q == NBW'(0)) keep_q <= rx_byte[0];
               OP_PROG: begin
                  if (nbyte_q == NBW'(0)) cfg_q  <= rx_byte;
                  else                    code_q <= {rx_byte, code_q[CW-1:8]};
               end
               default: ;
            endcase
         end
         // sequential write: the next data byte follows
         if ((st_q == S_WMEM || st_q == S_RESP) && st_d == S_ARG)
            nbyte_q <= NBW'(1);
         if (st_q == S_WMEM && mem_ack)
            addr_q <= addr_q + 1'b1;
         if (st_q == S_RMEM && mem_ack) begin
            rd_byte_q <= mem_rdata;
            bit_idx_q <= '0;
            drv_q     <= 1'b0;
         end
         if (st_q == S_ROUT) begin
            if (st_d == S_ABORT) begin
               drv_q <= 1'b0;
            end else if (hc_rise) begin
               rd_bit_q <= rd_byte_q[bit_idx_q];
               drv_q    <= 1'b1;
            end else if (hc_fall && drv_q) begin
               if (bit_idx_q == 3'd7) begin
                  addr_q <= addr_q + 1'b1;
                  drv_q  <= 1'b0;
               end else begin
                  bit_idx_q <= bit_idx_q + 3'd1;
               end
            end
         end
      end
   end

   // command strobes
   logic fire;
   assign fire = (st_q == S_COMMIT) && hc_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         learn_stb        <= 1'b0;
         erase_stb        <= 1'b0;
         prog_stb         <= 1'b0;
         erase_keep_first <= 1'b0;
         prog_cfg         <= '0;
         prog_code        <= '0;
      end else begin
         learn_stb <= fire && (op_q == OP_LEARN);
         erase_stb <= fire && (op_q == OP_ERASE);
         prog_stb  <= fire && (op_q == OP_PROG);
         if (fire && op_q == OP_ERASE) erase_keep_first <= keep_q;
         if (fire && op_q == OP_PROG) begin
            prog_cfg  <= cfg_q;
            prog_code <= code_q;
         end
      end
   end

   // line and memory port
   assign hdat_oe   = (st_q == S_REQ) || (st_q == S_ACKLO) || (st_q == S_RESP) ||
                      (st_q == S_ROUT && drv_q);
   assign hdat_o    = (st_q == S_REQ) || (st_q == S_RESP) ||
                      (st_q == S_ROUT && drv_q && rd_bit_q);
   assign mem_req   = (st_q == S_WMEM) || (st_q == S_RMEM);
   assign mem_we    = (st_q == S_WMEM);
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
endmodule

// File: rtl/hcm_cmd_rx_chk.sv
module hcm_cmd_rx_chk
   import hcm_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input rx_state_t         st,
   input logic              hdat_oe,
   input logic              learn_stb,
   input logic              erase_stb,
   input logic              prog_stb,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   logic any_stb;
   assign any_stb = learn_stb | erase_stb | prog_stb;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> (!hdat_oe && !mem_req));

   // R4
   rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CMD || st == S_ARG) |-> !hdat_oe);

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R9
   stb_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_stb |-> (st == S_RESP));

   // R12
   one_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({learn_stb, erase_stb, prog_stb}));

   // R12
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_stb |=> !any_stb);
endmodule

bind hcm_cmd_rx hcm_cmd_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st        (st_q),
   .hdat_oe   (hdat_oe),
   .learn_stb (learn_stb),
   .erase_stb (erase_stb),
   .prog_stb  (prog_stb),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/hcm_cmd_rx_tb_top.sv
`timescale 1ns/1ps
module hcm_cmd_rx_tb_top;
   localparam int ACKLO = 4;
   localparam int REQMX = 300;
   localparam int TMO   = 150;
   localparam int SEQW  = 100;
   localparam int HB    = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hc = 1'b0;
   logic        hd = 1'b0;
   logic        hdat_o, hdat_oe;
   logic        mem_req, mem_we, mem_ack;
   logic [6:0]  mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        learn_stb, erase_stb, erase_keep_first, prog_stb;
   logic [7:0]  prog_cfg;
   logic [63:0] prog_code;

   always #10 clk = ~clk;

   hcm_cmd_rx #(
      .ACK_LO_CYC(ACKLO), .REQ_MAX_CYC(REQMX),
      .IDLE_TMO_CYC(TMO), .SEQ_WIN_CYC(SEQW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .hclk_i(hc), .hdat_i(hd),
      .hdat_o(hdat_o), .hdat_oe(hdat_oe),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .learn_stb(learn_stb), .erase_stb(erase_stb),
      .erase_keep_first(erase_keep_first), .prog_stb(prog_stb),
      .prog_cfg(prog_cfg), .prog_code(prog_code)
   );

   // memory model and strobe monitor
   logic [7:0] bmem [128];
   logic [7:0] exp_mem [128];
   int lat = 0, wr_cnt = 0, n_learn = 0, n_erase = 0, n_prog = 0;
   logic last_keep = 1'b0;
   assign mem_rdata = bmem[mem_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         lat     <= 0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            if (lat == 1) begin
               mem_ack <= 1'b1;
               lat     <= 0;
               if (mem_we) begin
                  bmem[mem_addr] <= mem_wdata;
                  wr_cnt <= wr_cnt + 1;
               end
            end else lat <= lat + 1;
         end
         if (learn_stb) n_learn <= n_learn + 1;
         if (prog_stb)  n_prog  <= n_prog + 1;
         if (erase_stb) begin
            n_erase   <= n_erase + 1;
            last_keep <= erase_keep_first;
         end
      end
   end

   int  n_chk = 0, n_err = 0;
   bit  finished = 1'b0;
   bit  noisy = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_req();
      hc = 1'b1; cyc(6);
      chk(hdat_oe && hdat_o, "R2 request ack high", {hdat_oe, hdat_o}, 2'b11);
      hc = 1'b0; cyc(4);
      chk(hdat_oe && !hdat_o, "R2 ack low pulse", {hdat_oe, hdat_o}, 2'b10);
      cyc(ACKLO + 10);
      chk(!hdat_oe, "R2 line released", hdat_oe, 0);
   endtask

   // a rise seen as a fresh request proves the block sat in idle
   task automatic probe_idle(input string req);
      hc = 1'b1; cyc(6);
      chk(hdat_oe && hdat_o, req, {hdat_oe, hdat_o}, 2'b11);
      hc = 1'b0; cyc(ACKLO + 12);
      cyc(TMO + 60);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         cyc(2); hd = b[i];
         hc = 1'b1; cyc(HB / 2);
         if (hdat_oe) noisy = 1'b1;
         cyc(HB - HB / 2);
         hc = 1'b0; cyc(HB / 2);
         if (hdat_oe) noisy = 1'b1;
         cyc(HB - HB / 2);
      end
   endtask

   task automatic commit(output bit resp);
      hc = 1'b1; cyc(HB);
      resp = hdat_oe && hdat_o;
      hc = 1'b0; cyc(HB);
   endtask

   task automatic read_byte(output logic [7:0] b, output bit drv);
      drv = 1'b1;
      cyc(8);
      for (int i = 0; i < 8; i++) begin
         hc = 1'b1; cyc(HB / 2);
         b[i] = hdat_o;
         if (!hdat_oe) drv = 1'b0;
         cyc(HB - HB / 2);
         hc = 1'b0; cyc(HB);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      bit r;
      host_req();
      send_byte(8'hE1); send_byte(a); send_byte(d);
      commit(r);
      chk(r, "R6 write acknowledged high", r, 1);
      exp_mem[a[6:0]] = d;
      cyc(TMO + 60);
   endtask

   task automatic do_read(input logic [7:0] a, input int n, input string req);
      logic [7:0] b;
      bit drv;
      host_req();
      send_byte(8'hF0); send_byte(a); send_byte(8'h5C);
      for (int k = 0; k < n; k++) begin
         read_byte(b, drv);
         chk(drv && b == exp_mem[(a[6:0] + k) % 128], req, {drv, b},
             {1'b1, exp_mem[(a[6:0] + k) % 128]});
      end
   endtask

   initial begin
      int unsigned seed;
      logic [7:0]  a, d, cfg;
      logic [63:0] code;
      int          w0;
      bit          r;
      seed = $urandom(32'd515);
      for (int i = 0; i < 128; i++) begin
         bmem[i]    = 8'($urandom);
         exp_mem[i] = bmem[i];
      end

      // R1 reset state
      cyc(5);
      chk(!hdat_oe && !mem_req && !learn_stb && !erase_stb && !prog_stb,
          "R1 in reset", {hdat_oe, mem_req}, 0);
      rst_n = 1'b1; cyc(5);
      chk(!hdat_oe && !mem_req, "R1 after reset", {hdat_oe, mem_req}, 0);

      // R6 random writes, address bit 7 ignored
      for (int k = 0; k < 10; k++) begin
         a = 8'($urandom); d = 8'($urandom);
         if (k == 0) a = 8'hC5;
         do_write(a, d);
         chk(bmem[a[6:0]] == d, "R6 stored at truncated address", bmem[a[6:0]], d);
      end

      // R6 sequential write wrapping 127 -> 0
      host_req();
      send_byte(8'hE1); send_byte(8'h7F);
      send_byte(8'h3C); commit(r);
      chk(r, "R6 first seq write ack", r, 1);
      send_byte(8'h96); commit(r);
      chk(r, "R6 second seq write ack", r, 1);
      exp_mem[127] = 8'h3C; exp_mem[0] = 8'h96;
      cyc(TMO + 60);
      chk(bmem[127] == 8'h3C && bmem[0] == 8'h96, "R6 wrap write",
          {bmem[127], bmem[0]}, 16'h3C96);
      chk(!noisy, "R4 data released while shifting in", noisy, 0);

      // R7 reads, including sequential wrap
      for (int k = 0; k < 5; k++) begin
         a = 8'($urandom);
         do_read(a, 1, "R7 single read");
         cyc(TMO + SEQW + 60);
      end
      do_read(8'h7E, 3, "R7 sequential read across wrap");
      cyc(TMO + SEQW + 60);

      // R8 stall during write
      w0 = wr_cnt;
      host_req();
      send_byte(8'hE1); send_byte(8'h05);
      cyc(TMO + 250);
      probe_idle("R8 idle after write stall");
      chk(wr_cnt == w0, "R8 no write after stall", wr_cnt, w0);

      // R8 sequential read window expiry; next byte has bit0 = 0
      do_write(8'h0B, 8'h42);
      do_read(8'h0A, 1, "R7 read before window test");
      cyc(SEQW + 150);
      probe_idle("R8 idle after read window");

      // R3 stuck request
      hc = 1'b1; cyc(REQMX + 60);
      chk(!hdat_oe, "R3 request dropped", hdat_oe, 0);
      hc = 1'b0; cyc(5);
      chk(!hdat_oe, "R3 no low ack", hdat_oe, 0);
      cyc(20);
      probe_idle("R3 idle afterwards");

      // R5 unknown opcode
      host_req();
      send_byte(8'h5A); cyc(4);
      chk(!hdat_oe, "R5 unknown opcode not driven", hdat_oe, 0);
      probe_idle("R5 idle after unknown opcode");

      // R9 learn
      host_req();
      send_byte(8'hD2); send_byte(8'h00); send_byte(8'hFF);
      commit(r); cyc(4);
      chk(r, "R9 learn acknowledged", r, 1);
      chk(n_learn == 1, "R9 R12 one learn strobe", n_learn, 1);

      // R10 erase variants
      host_req();
      send_byte(8'hC3); send_byte(8'h00); send_byte(8'h00);
      commit(r); cyc(4);
      chk(r && n_erase == 1 && last_keep == 1'b0, "R10 erase all",
          {r, last_keep, 8'(n_erase)}, {1'b1, 1'b0, 8'd1});
      host_req();
      send_byte(8'hC3); send_byte(8'h01); send_byte(8'h00);
      commit(r); cyc(4);
      chk(r && n_erase == 2 && last_keep == 1'b1, "R10 erase keep first",
          {r, last_keep, 8'(n_erase)}, {1'b1, 1'b1, 8'd2});
      host_req();
      send_byte(8'hC3); send_byte(8'h02); cyc(4);
      chk(!hdat_oe, "R10 bad subcommand released", hdat_oe, 0);
      probe_idle("R10 idle after bad subcommand");
      chk(n_erase == 2, "R10 no strobe for bad subcommand", n_erase, 2);

      // R11 program, twice with random values
      for (int k = 0; k < 2; k++) begin
         cfg  = 8'($urandom);
         code = {32'($urandom), 32'($urandom)};
         host_req();
         send_byte(8'hB4); send_byte(cfg);
         for (int j = 0; j < 8; j++) send_byte(code[j*8 +: 8]);
         commit(r); cyc(4);
         chk(r && n_prog == k + 1, "R11 R12 program strobe", {r, 8'(n_prog)}, {1'b1, 8'(k + 1)});
         chk(prog_cfg == cfg, "R11 configuration byte", prog_cfg, cfg);
         chk(prog_code == code, "R11 code value", prog_code, code);
      end
      chk(n_learn == 1 && n_erase == 2, "R12 no stray strobes", {8'(n_learn), 8'(n_erase)}, 16'h0102);
      chk(!noisy, "R4 data released across run", noisy, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule